// File: doc/BRIEF.md
# Fractional-Increment PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control word. The word is written and read through a plain register port. The PWM frequency does not come from a terminal count. A 16-bit accumulator wraps modulo 65536 and gains a programmable step on every clock, so the output frequency is the clock frequency times the step divided by 65536. Each carry out of the accumulator begins a new PWM period. The duty cycle comes from an 8-bit threshold that is compared against the accumulator's top byte. A larger threshold gives a shorter high time. Software normally loads 255 minus 255 times the wanted duty fraction.

Software writes the step and the threshold into staging copies. These copies reach the running waveform only when software also raises an update request. They then take effect at the next period boundary, so a period already in progress is never torn. While the output is switched off there is no running period, and a pending request takes effect on the next clock. The enable bit is meant to be changed by read-modify-write. Reads return the staged fields, so writing back a read value leaves the settings as they were.

Top module: `pwm_phase_gen`

## Requirements
- R1: While reset is asserted and just after it is released, `rd_data` reads zero and `pwm_out` is low. Reset clears the enable, the pending request, all staged and active settings, and the accumulator.
- R2: A write loads bit 31 as enable, bits 23:8 as the staged step and bits 7:0 as the staged threshold. A read returns enable at bit 31, the pending request at bit 30, the staged step at bits 23:8 and the staged threshold at bits 7:0. Bits 29:24 read as zero.
- R3: While enabled, the accumulator adds the active step on every clock, modulo 65536. The carry out of that sum marks a period boundary. In the first cycle after enabling, the accumulator is zero.
- R4: `pwm_out` is high exactly when the block is enabled and the accumulator's bits 15:8 are greater than or equal to the active threshold. A threshold of 0 gives a constant high. A threshold of 255 gives high only while the top byte is 255.
- R5: Writing the step or the threshold without setting bit 30 leaves the waveform unchanged.
- R6: Writing 1 to bit 30 sets the pending request. Writing 0 to bit 30 leaves it unchanged. While enabled, the staged values become active on the clock where the accumulator wraps, and the pending request clears on that same clock. A new request written on that clock stays pending.
- R7: While disabled, a pending request is committed on the next clock, and the request reads back as cleared.
- R8: Clearing enable drives `pwm_out` low and resets the accumulator to zero. After enable is set again, the output follows a full period that starts at accumulator value zero.
- R9: With an active step of zero and the block enabled, the accumulator holds its value. The output therefore stays at the level the compare gives for that frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the accumulator advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes `wr_data` into the control word on this edge |
| wr_data | input | 32 | Control word to be written |
| rd_data | output | 32 | Current read view of the control word |
| pwm_out | output | 1 | PWM output |

## Verification
The properties assume that `rst_n` is asserted once before any check matters. They also assume that `wr_en` and `wr_data` hold known values at every rising edge, since a write with unknown bit 30 leaves the pending state undefined. The bench changes every input only on the falling clock edge and drives `wr_data` to zero whenever no write is taking place. It places each update request at a known phase inside a period, so the expected commit clock follows from the step alone. It loads the step-zero and disabled cases directly through the disabled-commit path, without waiting for a wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Control word geometry; enable and update positions are fixed by software.
  localparam int CTRL_W  = 32;
  localparam int EN_BIT  = 31;
  localparam int UPD_BIT = 30;
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              wrap,
  output logic              en,
  output logic              pending,
  output logic [ACC_W-1:0]  base_act,
  output logic [DIV_W-1:0]  div_act,
  output logic [CTRL_W-1:0] rd_data
);
  localparam int FIELD_TOP = DIV_W + ACC_W;

  logic [ACC_W-1:0] base_sh;
  logic [DIV_W-1:0] div_sh;
  logic             commit;
  logic             unused_hi;

  assign unused_hi = ^wr_data[UPD_BIT-1:FIELD_TOP];

  // A period boundary, or no running period at all, lets staged values in.
  assign commit = pending && (wrap || !en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      base_sh <= '0;
      div_sh  <= '0;
    end else if (wr_en) begin
      en      <= wr_data[EN_BIT];
      base_sh <= wr_data[DIV_W +: ACC_W];
      div_sh  <= wr_data[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (wr_en && wr_data[UPD_BIT]) begin
      pending <= 1'b1;
    end else if (commit) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_act <= '0;
      div_act  <= '0;
    end else if (commit) begin
      base_act <= base_sh;
      div_act  <= div_sh;
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[EN_BIT]            = en;
    rd_data[UPD_BIT]           = pending;
    rd_data[DIV_W +: ACC_W]    = base_sh;
    rd_data[DIV_W-1:0]         = div_sh;
  end
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc,
  output logic             wrap
);
  logic [ACC_W:0] sum;

  assign sum  = {1'b0, acc} + {1'b0, step};
  assign wrap = en && sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (!en) begin
      acc <= '0;
    end else begin
      acc <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
  parameter int ACC_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             en,
  input  logic [ACC_W-1:0] acc,
  input  logic [DIV_W-1:0] thresh,
  output logic             level
);
  logic [DIV_W-1:0] top_bits;

  assign top_bits = acc[ACC_W-1 -: DIV_W];
  assign level    = en && (top_bits >= thresh);
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              pwm_out
);
  logic             en_q;
  logic             pend_q;
  logic             wrap;
  logic [ACC_W-1:0] base_act;
  logic [DIV_W-1:0] div_act;
  logic [ACC_W-1:0] acc_q;

  pwm_ctrl_reg #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wrap     (wrap),
    .en       (en_q),
    .pending  (pend_q),
    .base_act (base_act),
    .div_act  (div_act),
    .rd_data  (rd_data)
  );

  pwm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_q),
    .step  (base_act),
    .acc   (acc_q),
    .wrap  (wrap)
  );

  pwm_duty_cmp #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_cmp (
    .en     (en_q),
    .acc    (acc_q),
    .thresh (div_act),
    .level  (pwm_out)
  );
endmodule

// File: rtl/pwm_phase_gen_chk.sv
module pwm_phase_gen_chk
  import pwm_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int DIV_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic              pwm_out,
  input logic              en,
  input logic              pending,
  input logic              wrap,
  input logic [ACC_W-1:0]  acc,
  input logic [ACC_W-1:0]  base_act,
  input logic [DIV_W-1:0]  div_act
);
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out); // R8

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc == '0)); // R8

  AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[UPD_BIT]) |=> pending); // R6

  AST_REQ_CLEAR_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(wrap || !en)); // R6

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && (wrap || !en)) |=> ($stable(base_act) && $stable(div_act))); // R5

  AST_ZERO_STEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && base_act == '0) |=> $stable(acc)); // R9
endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .pwm_out  (pwm_out),
  .en       (en_q),
  .pending  (pend_q),
  .wrap     (wrap),
  .acc      (acc_q),
  .base_act (base_act),
  .div_act  (div_act)
);

// File: tb/pwm_phase_gen_bench.sv
module pwm_phase_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_phase_gen u_pwm_phase_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word(input bit en, input bit upd, input int b, input int d);
    logic [31:0] w;
    w = '0;
    w[31] = en;
    w[30] = upd;
    w[23:8] = b[15:0];
    w[7:0] = d[7:0];
    return w;
  endfunction

  // Expected level k clocks after enabling with a constant step.
  function automatic bit exp_level(input int k, input int b, input int d);
    longint a;
    a = (longint'(k) * b) % 65536;
    return ((a >> 8) >= d);
  endfunction

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic start(input int b, input int d);
    wr(word(1'b0, 1'b1, b, d));
    wr(word(1'b1, 1'b0, b, d));
  endtask

  task automatic expect_run(input int b, input int d, input int n, input int k0, input string req);
    for (int i = 0; i < n; i++) begin
      chk(pwm_out == exp_level(k0 + i, b, d), req, pwm_out, exp_level(k0 + i, b, d));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bases[7];
    int divs[6];
    bases = '{32'h0100, 32'h0400, 32'h1000, 32'h4000, 32'h8000, 32'h8002, 32'h0BB8};
    divs  = '{0, 1, 8'h11, 8'h80, 8'hC8, 8'hFF};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rd_data == 32'h0, "R1", rd_data, 0);
    chk(pwm_out == 1'b0, "R1", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 32'h0, "R1", rd_data, 0);
    chk(pwm_out == 1'b0, "R1", pwm_out, 0);

    // R2 R3 R4: sweep of steps and thresholds, per-cycle waveform
    foreach (bases[bi]) begin
      foreach (divs[di]) begin
        int n;
        n = (bases[bi] == 32'h0100) ? 520 : 80;
        start(bases[bi], divs[di]);
        chk(rd_data == word(1'b1, 1'b0, bases[bi], divs[di]), "R2", rd_data,
            word(1'b1, 1'b0, bases[bi], divs[di]));
        expect_run(bases[bi], divs[di], n, 0, "R3 R4");
      end
    end

    // R2: unused bits 29:24 read as zero
    wr(32'h3F00_0000 | word(1'b0, 1'b0, 16'h1234, 8'h56));
    chk(rd_data == word(1'b0, 1'b0, 16'h1234, 8'h56), "R2", rd_data,
        word(1'b0, 1'b0, 16'h1234, 8'h56));

    // R5: staged write without request leaves the waveform alone
    start(32'h1000, 8'h80);
    expect_run(32'h1000, 8'h80, 3, 0, "R5");
    wr(word(1'b1, 1'b0, 32'h1000, 8'h00));
    expect_run(32'h1000, 8'h80, 32, 4, "R5");
    chk(rd_data == word(1'b1, 1'b0, 32'h1000, 8'h00), "R2", rd_data,
        word(1'b1, 1'b0, 32'h1000, 8'h00));

    // R6: request commits at the wrap (k = 48 with period 16)
    wr(word(1'b1, 1'b1, 32'h1000, 8'hC0));
    for (int k = 37; k < 70; k++) begin
      int d;
      d = (k < 48) ? 8'h80 : 8'hC0;
      chk(pwm_out == exp_level(k, 32'h1000, d), "R6", pwm_out, exp_level(k, 32'h1000, d));
      chk(rd_data[30] == (k < 48), "R6", rd_data[30], (k < 48));
      @(negedge clk);
    end

    // R8: disable forces low; re-enable restarts from zero
    wr(word(1'b0, 1'b0, 32'h1000, 8'hC0));
    for (int i = 0; i < 5; i++) begin
      chk(pwm_out == 1'b0, "R8", pwm_out, 0);
      @(negedge clk);
    end
    wr(word(1'b1, 1'b0, 32'h1000, 8'hC0));
    expect_run(32'h1000, 8'hC0, 32, 0, "R8");

    // R9: zero step freezes accumulator at zero; threshold 0 gives high
    start(0, 0);
    for (int i = 0; i < 10; i++) begin
      chk(pwm_out == 1'b1, "R9", pwm_out, 1);
      @(negedge clk);
    end
    // R6: request stays pending without a wrap; writing 0 to bit 30 keeps it
    wr(word(1'b1, 1'b1, 0, 5));
    chk(rd_data[30] == 1'b1, "R6", rd_data[30], 1);
    for (int i = 0; i < 10; i++) begin
      chk(pwm_out == 1'b1, "R9", pwm_out, 1);
      @(negedge clk);
    end
    wr(word(1'b1, 1'b0, 0, 5));
    chk(rd_data[30] == 1'b1, "R6", rd_data[30], 1);
    // R7: disabled, the pending request commits on the next clock
    wr(word(1'b0, 1'b0, 0, 5));
    @(negedge clk);
    chk(rd_data == word(1'b0, 1'b0, 0, 5), "R7", rd_data, word(1'b0, 1'b0, 0, 5));
    wr(word(1'b1, 1'b0, 0, 5));
    for (int i = 0; i < 10; i++) begin
      chk(pwm_out == 1'b0, "R7", pwm_out, 0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule